// File: doc/BRIEF.md
# Energy-Onset Speech Detector with Half-Overlap Frame Buffer

This block sits between an audio sample source and a 256-point FFT. It receives 16-bit signed samples, one per cycle in which `sampleValid` is high, at an audio rate of about 8 kHz. It groups them into blocks of 128 samples and forms an energy value for each block. Speech onset is declared from a rise in energy between one block and the next, not from an absolute level. Before onset, each block is written over the lower half of a 256-entry buffer.

When onset is seen, the triggering block stays in the lower half and the next block fills the upper half. That completes the first frame. From then on the write pointer moves round the buffer as a ring. Each further block of 128 samples completes a new 256-sample frame that overlaps the previous one by half. For every frame the block publishes the base address of its oldest sample and raises a one-cycle start pulse. The FFT then reads the frame through an index port that is relative to that base.

An utterance window is 4224 samples long, which gives 32 frames. After the last frame start, the block pulses `done` and becomes idle until it is armed again. If the FFT is still busy with an earlier frame, the start pulse is held back until it is free.

Top module: `speech_onset_framer`

## Requirements
- R1: After reset, and whenever the block is not armed, `speech`, `fftStart` and `done` are low. Samples offered while not armed cause no start pulse and no onset.
- R2: Block energy is the sum of the squares of the 128 signed samples of a block. Onset is declared at the end of a block whose energy is strictly greater than the previous block's energy plus `threshold`. A rise exactly equal to `threshold` is not onset. `speech` goes high the cycle after the block's last sample.
- R3: The first block after arming has no previous block, so it is never an onset, however loud it is.
- R4: While listening, every block is written to addresses 0..127, overwriting the one before. No `fftStart` is raised before the block that follows the onset block has been completely received.
- R5: `fftStart` is a one-cycle pulse in the cycle after the last sample of each frame. One frame completes every 128 accepted samples after the onset block.
- R6: `fftBase` holds the address of a frame's oldest sample whenever `fftStart` is high. It is 0 for the first frame and then alternates 128, 0, 128, ...
- R7: `rdData` returns the buffer entry at address (`fftBase` + `rdIdx`) mod 256 one cycle after `rdIdx` is presented. For index i of frame n (n counted from 0) this is sample (D+n)*128+i of the stream since arming, where D is the index of the onset block.
- R8: After the 32nd frame start, `done` is high for exactly one cycle, in the following cycle, and `speech` is low from that same cycle on. Samples offered after that cause no start pulse until the block is armed again.
- R9: While `fftBusy` is high, a ready frame's `fftStart` is withheld. It is raised in the first cycle in which `fftBusy` is low.
- R10: A cycle with `sampleValid` low neither writes the buffer nor advances the block position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armIn | input | 1 | Pulse that arms onset detection when idle |
| sampleValid | input | 1 | A sample is present on `sampleData` this cycle |
| sampleData | input | 16 | Signed audio sample |
| threshold | input | 39 | Required energy rise for onset |
| fftBusy | input | 1 | FFT is still reading an earlier frame |
| rdIdx | input | 8 | Read index relative to the frame base |
| speech | output | 1 | Onset has been found and framing is running |
| fftStart | output | 1 | One-cycle pulse: a new frame is ready |
| fftBase | output | 8 | Buffer address of the frame's oldest sample |
| rdData | output | 16 | Buffer entry at base plus index, one cycle after `rdIdx` |
| done | output | 1 | One-cycle pulse after the last frame of the window |

## Verification
The bench compares energy rises that equal the threshold with rises that exceed it by one step. A comparison with `>=` would declare onset one block early and shift every frame. It also offers a very loud first block after arming: a design that treats the missing previous energy as zero would trigger there. Frame readback is checked at both halves of the ring, with idle gaps mixed into the sample stream. A pointer that advances on idle cycles, or a base that is off by one, returns the wrong samples. The bench also holds `fftBusy` across a frame boundary and asserts it during the last frame. A design that drops the request, pulses while busy, or leaves the window without a start would show up in the pulse timing and in the count of 32 frames before `done`.

// File: rtl/vfr_pkg.sv
package vfr_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // start a fresh listening session
    logic accept;    // write the current sample and accumulate it
    logic rewind;    // block ended without onset: restart at address 0
    logic loadBase;  // a frame just completed: capture its base address
  } vfStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LISTEN,
    ST_STREAM,
    ST_DRAIN
  } vfState_t;

endpackage

// File: rtl/vfr_datapath.sv
module vfr_datapath
  import vfr_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int BLOCK_LEN  = 128,
  parameter int USE_SQUARE = 1,
  localparam int DEPTH     = 2 * BLOCK_LEN,
  localparam int AW        = $clog2(DEPTH),
  localparam int BW        = $clog2(BLOCK_LEN),
  localparam int EW        = 2 * SAMPLE_W + BW
) (
  input  logic                clk,
  input  logic                rstN,
  input  vfStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [EW-1:0]       threshold,
  input  logic [AW-1:0]       rdIdx,
  output logic                atBlockEnd,
  output logic                onsetHit,
  output logic [AW-1:0]       fftBase,
  output logic [AW-1:0]       wrPtr,
  output logic [SAMPLE_W-1:0] rdData
);

  logic [SAMPLE_W-1:0] frameMem [DEPTH];
  logic [EW-1:0]       accQ;
  logic [EW-1:0]       prevEnergyQ;
  logic                prevValidQ;
  logic [EW-1:0]       sampleMag;
  logic [EW-1:0]       blockEnergy;
  logic [EW:0]         lhsWide;
  logic [EW:0]         rhsWide;

  // Per-sample contribution: a square, or a magnitude when chosen at build time
  generate
    if (USE_SQUARE != 0) begin : g_square
      logic signed [2*SAMPLE_W-1:0] sq;
      assign sq        = $signed(sampleData) * $signed(sampleData);
      assign sampleMag = EW'(unsigned'(sq));
    end else begin : g_abs
      logic signed [SAMPLE_W:0] ext;
      logic        [SAMPLE_W:0] mag;
      assign ext       = {sampleData[SAMPLE_W-1], sampleData};
      assign mag       = ext[SAMPLE_W] ? unsigned'(-ext) : unsigned'(ext);
      assign sampleMag = EW'(mag);
    end
  endgenerate

  assign atBlockEnd  = &wrPtr[BW-1:0];
  assign blockEnergy = accQ + sampleMag;
  assign lhsWide     = {1'b0, blockEnergy};
  assign rhsWide     = {1'b0, prevEnergyQ} + {1'b0, threshold};
  assign onsetHit    = prevValidQ && (lhsWide > rhsWide);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      accQ        <= '0;
      prevEnergyQ <= '0;
      prevValidQ  <= 1'b0;
      fftBase     <= '0;
    end else if (strobe.clear) begin
      wrPtr       <= '0;
      accQ        <= '0;
      prevEnergyQ <= '0;
      prevValidQ  <= 1'b0;
      fftBase     <= '0;
    end else begin
      if (strobe.accept) begin
        if (atBlockEnd) begin
          accQ        <= '0;
          prevEnergyQ <= blockEnergy;
          prevValidQ  <= 1'b1;
        end else begin
          accQ <= blockEnergy;
        end
        wrPtr <= strobe.rewind ? '0 : wrPtr + 1'b1;
      end
      if (strobe.loadBase) begin
        fftBase <= wrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      frameMem[wrPtr] <= sampleData;
    end
  end

  always_ff @(posedge clk) begin
    rdData <= frameMem[AW'(fftBase + rdIdx)];
  end

  // R6
  base_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBase |-> (atBlockEnd && strobe.accept));

endmodule

// File: rtl/vfr_control.sv
module vfr_control
  import vfr_pkg::*;
#(
  parameter int NUM_FRAMES = 32,
  localparam int CW        = $clog2(NUM_FRAMES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      armIn,
  input  logic      sampleValid,
  input  logic      fftBusy,
  input  logic      atBlockEnd,
  input  logic      onsetHit,
  output vfStrobe_t strobe,
  output logic      fftStart,
  output logic      done,
  output logic      speech,
  output logic      listening
);

  vfState_t      stateQ;
  logic          pendingQ;
  logic [CW-1:0] readyCntQ;
  logic          blockDone;
  logic          lastFrame;

  assign listening = (stateQ == ST_LISTEN);
  assign speech    = (stateQ == ST_STREAM) || (stateQ == ST_DRAIN);

  always_comb begin
    strobe          = '0;
    strobe.clear    = (stateQ == ST_IDLE) && armIn;
    strobe.accept   = sampleValid && (listening || (stateQ == ST_STREAM));
    blockDone       = strobe.accept && atBlockEnd;
    strobe.rewind   = listening && blockDone && !onsetHit;
    strobe.loadBase = (stateQ == ST_STREAM) && blockDone;
  end

  assign lastFrame = (readyCntQ == CW'(NUM_FRAMES - 1));
  assign fftStart  = pendingQ && !fftBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      pendingQ  <= 1'b0;
      readyCntQ <= '0;
      done      <= 1'b0;
    end else begin
      done     <= 1'b0;
      pendingQ <= (pendingQ && !fftStart) || strobe.loadBase;
      if (strobe.loadBase) begin
        readyCntQ <= readyCntQ + 1'b1;
      end
      unique case (stateQ)
        ST_IDLE: begin
          if (armIn) begin
            stateQ    <= ST_LISTEN;
            readyCntQ <= '0;
          end
        end
        ST_LISTEN: begin
          if (blockDone && onsetHit) begin
            stateQ <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (strobe.loadBase && lastFrame) begin
            stateQ <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (fftStart) begin
            stateQ <= ST_IDLE;
            done   <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && fftBusy) |=> pendingQ);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(fftStart) && !speech));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |-> !pendingQ);

endmodule

// File: rtl/speech_onset_framer.sv
module speech_onset_framer
  import vfr_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int BLOCK_LEN   = 128,
  parameter int UTT_SAMPLES = 4224,
  parameter int USE_SQUARE  = 1,
  localparam int FRAME_LEN  = 2 * BLOCK_LEN,
  localparam int NUM_FRAMES = (UTT_SAMPLES - FRAME_LEN) / BLOCK_LEN + 1,
  localparam int AW         = $clog2(FRAME_LEN),
  localparam int EW         = 2 * SAMPLE_W + $clog2(BLOCK_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                armIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [EW-1:0]       threshold,
  input  logic                fftBusy,
  input  logic [AW-1:0]       rdIdx,
  output logic                speech,
  output logic                fftStart,
  output logic [AW-1:0]       fftBase,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                done
);

  vfStrobe_t     strobe;
  logic          atBlockEnd;
  logic          onsetHit;
  logic          listening;
  logic [AW-1:0] wrPtr;

  vfr_control #(
    .NUM_FRAMES (NUM_FRAMES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .armIn       (armIn),
    .sampleValid (sampleValid),
    .fftBusy     (fftBusy),
    .atBlockEnd  (atBlockEnd),
    .onsetHit    (onsetHit),
    .strobe      (strobe),
    .fftStart    (fftStart),
    .done        (done),
    .speech      (speech),
    .listening   (listening)
  );

  vfr_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .BLOCK_LEN  (BLOCK_LEN),
    .USE_SQUARE (USE_SQUARE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleData (sampleData),
    .threshold  (threshold),
    .rdIdx      (rdIdx),
    .atBlockEnd (atBlockEnd),
    .onsetHit   (onsetHit),
    .fftBase    (fftBase),
    .wrPtr      (wrPtr),
    .rdData     (rdData)
  );

  // R4
  listen_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    listening |-> (wrPtr < AW'(BLOCK_LEN)));

  // R2
  onset_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(speech) |-> $past(onsetHit));

endmodule

// File: tb/sim_speech_onset_framer.sv
module sim_speech_onset_framer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armIn = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [38:0] threshold = '0;
  logic        fftBusy = 1'b0;
  logic [7:0]  rdIdx = '0;
  logic        speech;
  logic        fftStart;
  logic [7:0]  fftBase;
  logic [15:0] rdData;
  logic        done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic signed [15:0] hist [0:8191];
  int  nh = 0;
  bit  sawStart = 0;
  bit  det;
  int  onsetBlk;
  int  stallFrame;
  bit  finished;

  always #5 clk = ~clk;

  speech_onset_framer u0 (
    .clk(clk), .rstN(rstN), .armIn(armIn), .sampleValid(sampleValid),
    .sampleData(sampleData), .threshold(threshold), .fftBusy(fftBusy),
    .rdIdx(rdIdx), .speech(speech), .fftStart(fftStart), .fftBase(fftBase),
    .rdData(rdData), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  function automatic longint blkE(input int b);
    longint s = 0;
    for (int i = 0; i < 128; i++) begin
      s += longint'(hist[b*128+i]) * longint'(hist[b*128+i]);
    end
    return s;
  endfunction

  // kind: 0 constant amp, 1 random within +-amp, 2 full-range random
  function automatic logic [15:0] genSample(input int kind, input int amp);
    int v;
    if (kind == 0) return 16'(amp);
    if (kind == 1) begin
      v = int'($urandom_range(2 * amp)) - amp;
      return 16'(v);
    end
    return 16'($urandom);
  endfunction

  task automatic feedBlock(input int kind, input int amp);
    logic [15:0] v;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (fftStart) sawStart = 1;
      if ($urandom_range(3) == 0) begin
        sampleValid = 1'b0;
        @(negedge clk);
        if (fftStart) sawStart = 1;
      end
      v = genSample(kind, amp);
      sampleValid = 1'b1;
      sampleData = v;
      hist[nh] = v;
      nh++;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    armIn = 1'b1;
    @(negedge clk);
    armIn = 1'b0;
    nh = 0;
    det = 0;
    onsetBlk = -1;
    finished = 0;
  endtask

  task automatic readCheck(input int n, input int idx);
    @(negedge clk);
    rdIdx = 8'(idx);
    @(negedge clk);
    chk(rdData == hist[(onsetBlk + n) * 128 + idx], "R7 R10 frame readback",
        longint'(rdData), longint'(hist[(onsetBlk + n) * 128 + idx]));
  endtask

  task automatic afterBlock(input int b);
    int n;
    if (!det && b >= 1 && blkE(b) > blkE(b - 1) + longint'(threshold)) begin
      det = 1;
      onsetBlk = b;
    end
    chk(speech == det, "R2 R3 onset decision", longint'(speech), longint'(det));
    if (!det || b == onsetBlk) begin
      chk(fftStart == 1'b0, "R4 no start before frame full", longint'(fftStart), 0);
      return;
    end
    n = b - onsetBlk - 1;
    if (n == stallFrame) begin
      chk(fftStart == 1'b0, "R9 start withheld while busy", longint'(fftStart), 0);
      repeat (4) @(negedge clk);
      chk(fftStart == 1'b0, "R9 still withheld", longint'(fftStart), 0);
      fftBusy = 1'b0;
      #1;
    end
    chk(fftStart == 1'b1, "R5 R9 start pulse", longint'(fftStart), 1);
    chk(fftBase == ((n % 2) ? 8'd128 : 8'd0), "R6 frame base", longint'(fftBase),
        longint'((n % 2) ? 128 : 0));
    @(negedge clk);
    chk(fftStart == 1'b0, "R5 single-cycle pulse", longint'(fftStart), 0);
    if (n == 31) begin
      chk(done == 1'b1, "R8 done after last frame", longint'(done), 1);
      chk(speech == 1'b0, "R8 idle after done", longint'(speech), 0);
      finished = 1;
    end
    readCheck(n, 0);
    if (n == 31) chk(done == 1'b0, "R8 done lasts one cycle", longint'(done), 0);
    readCheck(n, 255);
    readCheck(n, 127);
    readCheck(n, 128);
    readCheck(n, int'($urandom_range(255)));
  endtask

  task automatic runUtter(input int mode);
    int b = 0;
    int quietN = 2 + int'($urandom_range(2));
    while (!finished) begin
      if (det && (b - onsetBlk - 1) == stallFrame) fftBusy = 1'b1;
      if (det) feedBlock(2, 0);
      else if (mode == 0) begin
        case (b)
          0: feedBlock(0, 300);  // loud first block: R3
          1: feedBlock(0, 0);
          2: feedBlock(0, 10);   // rise equals threshold: R2
          3: feedBlock(0, 0);
          default: feedBlock(0, 11);
        endcase
      end else begin
        if (b < quietN) feedBlock(1, 30);
        else feedBlock(1, 3000);
      end
      afterBlock(b);
      b++;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(fftStart == 0 && done == 0 && speech == 0, "R1 reset state",
        longint'({speech, fftStart, done}), 0);
    rstN = 1'b1;

    // Not armed: samples must be ignored
    threshold = 39'd100;
    sawStart = 0;
    feedBlock(0, 0);
    feedBlock(0, 2000);
    feedBlock(0, 0);
    feedBlock(0, 2000);
    chk(speech == 0, "R1 unarmed no onset", longint'(speech), 0);
    chk(sawStart == 0, "R1 unarmed no start", longint'(sawStart), 0);

    // Directed utterance, stall on frame 3
    threshold = 39'd12800;
    stallFrame = 3;
    arm();
    runUtter(0);
    chk(onsetBlk == 4, "R2 R3 directed onset block", onsetBlk, 4);

    // After done: ignored until armed
    sawStart = 0;
    feedBlock(0, 0);
    feedBlock(0, 5000);
    chk(speech == 0 && sawStart == 0, "R8 ignored after done",
        longint'({speech, sawStart}), 0);

    // Random utterance, stall on first and last frame
    threshold = 39'(1000000 + $urandom_range(2000000));
    stallFrame = 0;
    arm();
    runUtter(1);
    chk(onsetBlk >= 1, "R2 random onset found", onsetBlk, 1);

    threshold = 39'(500000 + $urandom_range(500000));
    stallFrame = 31;
    arm();
    runUtter(1);
    chk(speech == 0, "R8 final idle", longint'(speech), 0);

    summary();
  end

endmodule